// File: doc/BRIEF.md
# Byte ALU with Compare Flags

This block is the combinational arithmetic and logic unit of a small 8-bit processor datapath. It takes a first operand A (normally the destination register) and a second operand B (a source register or an immediate holding register). It also takes a decoded operation code and three modifier bits. From these it produces an 8-bit result and three comparison flags. The surrounding datapath captures the flags in its own registers and writes the result back. Neither is held here.

The one-step operation covers both increment and decrement, chosen by a modifier bit. The shift operation always moves by exactly one bit position; two modifier bits select its direction and its mode. The compare operation treats both operands as signed two's-complement values. It raises exactly one of three flags and drives a zero result. Every other operation keeps all three flags low.

Top module: `byte_alu`

## Requirements
- R1: With op code 0 the result is (A + B) mod 256. With op code 2 the result is (A - B) mod 256. No carry or overflow output exists.
- R2: Op code 3 gives A AND B, op code 4 gives A OR B, and op code 5 gives A XOR B, all bitwise.
- R3: Op code 1 is a one-step operation. With step_down_i = 0 the result is (A + 1) mod 256, so 0xFF gives 0x00. With step_down_i = 1 the result is (A - 1) mod 256, so 0x00 gives 0xFF.
- R4: Op code 6 passes B to the result unchanged, whatever the value of A.
- R5: Op code 8 with shift_right_i = 0 shifts A left by one and puts 0 into bit 0, whatever the value of shift_arith_i.
- R6: Op code 8 with shift_right_i = 1 shifts A right by one. Bit 7 receives 0 when shift_arith_i = 0 and a copy of A[7] when shift_arith_i = 1.
- R7: Op code 7 compares A and B as signed 8-bit values. It raises exactly one flag: gt_o when A > B, lt_o when A < B, eq_o when A == B. The result is 0x00.
- R8: For every op code other than 7, eq_o, lt_o and gt_o are all 0.
- R9: Op codes 9 to 15 give a result of 0x00 and no flags.
- R10: The modifier bits step_down_i, shift_right_i and shift_arith_i do not change the result of op codes 0, 2, 3, 4, 5, 6 or 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opnd_a_i | input | 8 | First operand A |
| opnd_b_i | input | 8 | Second operand B (register or immediate) |
| op_i | input | 4 | Decoded operation code (see R1 to R9) |
| step_down_i | input | 1 | One-step operation: 0 increments, 1 decrements |
| shift_right_i | input | 1 | Shift direction: 0 left, 1 right |
| shift_arith_i | input | 1 | Shift mode: 0 logical, 1 arithmetic |
| result_o | output | 8 | Operation result |
| eq_o | output | 1 | Compare: A equals B |
| lt_o | output | 1 | Compare: A less than B (signed) |
| gt_o | output | 1 | Compare: A greater than B (signed) |

## Verification
The block holds no state. A fault in a sub-unit or in the selection logic therefore shows on result_o or the flags in the same cycle the operands are applied, and only for the operation codes that use the faulty path. The bench changes the inputs every cycle and compares against a signed integer model. This catches a wrong fill bit, a swapped flag, or a compare done as unsigned on the first vector that exercises it. Operands that straddle the sign boundary (0x7F against 0x80) are included on purpose.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

    typedef enum logic [3:0] {
        OP_ADD   = 4'd0,
        OP_STEP  = 4'd1,
        OP_SUB   = 4'd2,
        OP_AND   = 4'd3,
        OP_OR    = 4'd4,
        OP_XOR   = 4'd5,
        OP_PASS  = 4'd6,
        OP_CMP   = 4'd7,
        OP_SHIFT = 4'd8
    } alu_op_e;

    typedef struct packed {
        logic eq;
        logic lt;
        logic gt;
    } cmp_flags_t;

endpackage

// File: rtl/alu8_arith.sv
module alu8_arith
    import alu8_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    input  alu_op_e          op_i,
    input  logic             step_down_i,
    output logic [WIDTH-1:0] sum_o
);
    localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

    logic [WIDTH-1:0] addend_d;
    logic             negate_d;

    always_comb begin
        negate_d = 1'b0;
        addend_d = b_i;
        case (op_i)
            OP_SUB:  negate_d = 1'b1;
            OP_STEP: begin
                addend_d = ONE;
                negate_d = step_down_i;
            end
            default: ;
        endcase
    end

    // one shared adder: subtraction uses inverted addend plus carry-in
    assign sum_o = a_i + (negate_d ? ~addend_d : addend_d) + {{(WIDTH-1){1'b0}}, negate_d};

endmodule

// File: rtl/alu8_bitwise.sv
module alu8_bitwise
    import alu8_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    input  alu_op_e          op_i,
    output logic [WIDTH-1:0] bits_o
);
    always_comb begin
        case (op_i)
            OP_AND:  bits_o = a_i & b_i;
            OP_OR:   bits_o = a_i | b_i;
            OP_XOR:  bits_o = a_i ^ b_i;
            OP_PASS: bits_o = b_i;
            default: bits_o = '0;
        endcase
    end
endmodule

// File: rtl/alu8_shift1.sv
module alu8_shift1 #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic             right_i,
    input  logic             arith_i,
    output logic [WIDTH-1:0] shifted_o
);
    localparam int MSB = WIDTH - 1;

    logic             top_fill;
    logic [WIDTH-1:0] left_val;
    logic [WIDTH-1:0] right_val;

    assign top_fill = arith_i & a_i[MSB];

    genvar i;
    generate
        for (i = 0; i < WIDTH; i++) begin : g_bit
            if (i == 0) begin : g_lsb
                assign left_val[i] = 1'b0;
            end else begin : g_mid_l
                assign left_val[i] = a_i[i-1];
            end
            if (i == MSB) begin : g_msb
                assign right_val[i] = top_fill;
            end else begin : g_mid_r
                assign right_val[i] = a_i[i+1];
            end
        end
    endgenerate

    assign shifted_o = right_i ? right_val : left_val;
endmodule

// File: rtl/alu8_compare.sv
module alu8_compare
    import alu8_pkg::*;
#(
    parameter int WIDTH = 8,
    parameter bit SIGNED_CMP = 1'b1
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    output cmp_flags_t       flags_o
);
    logic a_below;

    generate
        if (SIGNED_CMP) begin : g_signed
            assign a_below = $signed(a_i) < $signed(b_i);
        end else begin : g_unsigned
            assign a_below = a_i < b_i;
        end
    endgenerate

    assign flags_o.eq = (a_i == b_i);
    assign flags_o.lt = a_below;
    assign flags_o.gt = ~a_below & (a_i != b_i);
endmodule

// File: rtl/byte_alu.sv
module byte_alu
    import alu8_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] opnd_a_i,
    input  logic [WIDTH-1:0] opnd_b_i,
    input  logic [3:0]       op_i,
    input  logic             step_down_i,
    input  logic             shift_right_i,
    input  logic             shift_arith_i,
    output logic [WIDTH-1:0] result_o,
    output logic             eq_o,
    output logic             lt_o,
    output logic             gt_o
);
    localparam int MSB = WIDTH - 1;

    typedef struct packed {
        logic [WIDTH-1:0] res;
        cmp_flags_t       flags;
    } alu_out_t;

    alu_op_e          op;
    logic [WIDTH-1:0] sum_w;
    logic [WIDTH-1:0] bits_w;
    logic [WIDTH-1:0] shift_w;
    cmp_flags_t       cmp_w;
    alu_out_t         out_d;

    assign op = alu_op_e'(op_i);

    alu8_arith #(.WIDTH(WIDTH)) arith_i (
        .a_i(opnd_a_i), .b_i(opnd_b_i), .op_i(op),
        .step_down_i(step_down_i), .sum_o(sum_w)
    );

    alu8_bitwise #(.WIDTH(WIDTH)) bitwise_i (
        .a_i(opnd_a_i), .b_i(opnd_b_i), .op_i(op), .bits_o(bits_w)
    );

    alu8_shift1 #(.WIDTH(WIDTH)) shift_i (
        .a_i(opnd_a_i), .right_i(shift_right_i), .arith_i(shift_arith_i),
        .shifted_o(shift_w)
    );

    alu8_compare #(.WIDTH(WIDTH), .SIGNED_CMP(1'b1)) compare_i (
        .a_i(opnd_a_i), .b_i(opnd_b_i), .flags_o(cmp_w)
    );

    always_comb begin
        out_d = '0;
        case (op)
            OP_ADD, OP_SUB, OP_STEP:        out_d.res   = sum_w;
            OP_AND, OP_OR, OP_XOR, OP_PASS: out_d.res   = bits_w;
            OP_SHIFT:                       out_d.res   = shift_w;
            OP_CMP:                         out_d.flags = cmp_w;
            default: ;
        endcase
    end

    assign result_o = out_d.res;
    assign eq_o     = out_d.flags.eq;
    assign lt_o     = out_d.flags.lt;
    assign gt_o     = out_d.flags.gt;

    // immediate checks across the sub-units and the output selection
    always_comb begin
        if (op_i == 4'd7) begin
            a_r7_one_flag: assert ($countones({eq_o, lt_o, gt_o}) == 1)
                else $error("R7 compare must raise exactly one flag");
            a_r7_zero_result: assert (result_o == '0)
                else $error("R7 compare result must be zero");
        end else begin
            a_r8_flags_idle: assert ({eq_o, lt_o, gt_o} == 3'b000)
                else $error("R8 flags raised outside compare");
        end
        if (op_i == 4'd6) begin
            a_r4_pass_b: assert (result_o == opnd_b_i)
                else $error("R4 pass must copy B");
        end
        if (op_i == 4'd1) begin
            a_r3_step_unit: assert ((step_down_i ? (result_o + 1'b1) : (result_o - 1'b1)) == opnd_a_i)
                else $error("R3 step must move A by one");
        end
        if (op_i == 4'd8 && shift_right_i) begin
            a_r6_top_fill: assert (result_o[MSB] == (shift_arith_i & opnd_a_i[MSB]))
                else $error("R6 right-shift fill bit wrong");
        end
        if (op_i == 4'd8 && !shift_right_i) begin
            a_r5_low_zero: assert (result_o[0] == 1'b0)
                else $error("R5 left shift must fill zero");
        end
    end

endmodule

// File: tb/byte_alu_tb_top.sv
module byte_alu_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] a, b;
    logic [3:0] op;
    logic       dn, rt, ar;
    logic [7:0] res;
    logic       eq, lt, gt;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    byte_alu dut_i (
        .opnd_a_i(a), .opnd_b_i(b), .op_i(op),
        .step_down_i(dn), .shift_right_i(rt), .shift_arith_i(ar),
        .result_o(res), .eq_o(eq), .lt_o(lt), .gt_o(gt)
    );

    // behavioural reference: integer arithmetic, signed compare by value
    function automatic void model(input logic [7:0] ma, mb, input logic [3:0] mop,
                                  input logic mdn, mrt, mar,
                                  output logic [7:0] r, output logic [2:0] f);
        int ia, ib, sa, sb;
        ia = int'(ma); ib = int'(mb);
        sa = (ia > 127) ? ia - 256 : ia;
        sb = (ib > 127) ? ib - 256 : ib;
        r = 8'h00; f = 3'b000;
        case (mop)
            4'd0: r = 8'((ia + ib) % 256);
            4'd1: r = mdn ? 8'((ia + 255) % 256) : 8'((ia + 1) % 256);
            4'd2: r = 8'((ia - ib + 256) % 256);
            4'd3: r = ma & mb;
            4'd4: r = ma | mb;
            4'd5: r = ma ^ mb;
            4'd6: r = mb;
            4'd7: f = (sa == sb) ? 3'b100 : ((sa < sb) ? 3'b010 : 3'b001);
            4'd8: begin
                if (!mrt) r = 8'((ia * 2) % 256);
                else      r = 8'(ia / 2) | ((mar && ia >= 128) ? 8'h80 : 8'h00);
            end
            default: ;
        endcase
    endfunction

    function automatic string tag_of(input logic [3:0] mop, input logic mrt);
        case (mop)
            4'd0, 4'd2: return "R1";
            4'd1:       return "R3";
            4'd3, 4'd4, 4'd5: return "R2";
            4'd6:       return "R4";
            4'd7:       return "R7";
            4'd8:       return mrt ? "R6" : "R5";
            default:    return "R9";
        endcase
    endfunction

    task automatic check(input string tag, input logic [7:0] er, input logic [2:0] ef);
        checks++;
        if (res !== er || {eq, lt, gt} !== ef) begin
            errors++;
            $display("FAIL %s op=%0d a=%h b=%h: result=%h flags=%b expected result=%h flags=%b",
                     tag, op, a, b, res, {eq, lt, gt}, er, ef);
        end
    endtask

    task automatic apply(input logic [3:0] mop, input logic [7:0] ma, mb,
                         input logic mdn, mrt, mar, input string tag);
        logic [7:0] er;
        logic [2:0] ef;
        @(posedge clk);
        op = mop; a = ma; b = mb; dn = mdn; rt = mrt; ar = mar;
        model(ma, mb, mop, mdn, mrt, mar, er, ef);
        @(negedge clk);
        check(tag, er, ef);
        if (mop != 4'd7) begin
            checks++;
            if ({eq, lt, gt} !== 3'b000) begin
                errors++;
                $display("FAIL R8 op=%0d flags=%b expected 000", mop, {eq, lt, gt});
            end
        end
    endtask

    task automatic vec(input logic [3:0] mop, input logic [7:0] ma, mb,
                       input logic mdn, mrt, mar);
        apply(mop, ma, mb, mdn, mrt, mar, tag_of(mop, mrt));
    endtask

    initial begin
        a = 8'h00; b = 8'h00; op = 4'd0; dn = 1'b0; rt = 1'b0; ar = 1'b0;
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 idle", 8'h00, 3'b000);

        // R1 add/sub with wrap
        vec(4'd0, 8'hF0, 8'h20, 0, 0, 0);
        vec(4'd0, 8'hFF, 8'h01, 0, 0, 0);
        vec(4'd2, 8'h05, 8'h07, 0, 0, 0);
        vec(4'd2, 8'h80, 8'h01, 0, 0, 0);
        // R2 bitwise
        vec(4'd3, 8'hC3, 8'hA5, 0, 0, 0);
        vec(4'd4, 8'hC3, 8'hA5, 0, 0, 0);
        vec(4'd5, 8'hC3, 8'hA5, 0, 0, 0);
        // R3 step with wrap in both directions
        vec(4'd1, 8'hFF, 8'h33, 0, 0, 0);
        vec(4'd1, 8'h00, 8'h33, 1, 0, 0);
        vec(4'd1, 8'h7F, 8'h00, 0, 0, 0);
        vec(4'd1, 8'h80, 8'h00, 1, 0, 0);
        // R4 pass B
        vec(4'd6, 8'hAA, 8'h3C, 0, 0, 0);
        // R5 left shift, both modes
        vec(4'd8, 8'hC1, 8'h00, 0, 0, 0);
        vec(4'd8, 8'hC1, 8'h00, 0, 0, 1);
        // R6 right shift, sign handling
        vec(4'd8, 8'h81, 8'h00, 0, 1, 0);
        vec(4'd8, 8'h81, 8'h00, 0, 1, 1);
        vec(4'd8, 8'h42, 8'h00, 0, 1, 1);
        // R7 signed compare at the sign boundary
        vec(4'd7, 8'h7F, 8'h80, 0, 0, 0);
        vec(4'd7, 8'h80, 8'h7F, 0, 0, 0);
        vec(4'd7, 8'hFF, 8'h01, 0, 0, 0);
        vec(4'd7, 8'h5A, 8'h5A, 0, 0, 0);
        vec(4'd7, 8'h02, 8'h01, 0, 0, 0);
        // R9 unused op codes
        for (int k = 9; k < 16; k++) vec(4'(k), 8'hA7, 8'h5E, 1, 1, 1);
        // R10 modifier bits ignored by non-step, non-shift ops
        for (int k = 0; k < 8; k++) begin
            if (k != 1) apply(4'(k), 8'h93, 8'h6C, 1, 1, 1, "R10");
        end
        // broad sweep, R8 checked on every non-compare vector
        for (int n = 0; n < 400; n++) begin
            logic [31:0] rv;
            rv = $urandom;
            vec(4'(rv[3:0] % 9), rv[11:4], rv[19:12], rv[20], rv[21], rv[22]);
        end

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule